// File: doc/BRIEF.md
# Serial-In Latched Parallel Port Expander

This block gives a microcontroller nine extra output lines while using only two of its pins: a serial clock and a serial data line. On each rising edge of the serial clock, the block samples the data line and shifts the inverted level into a nine-stage register. The newest bit enters at the stage behind output 1, and older bits move toward stage 9.

No separate strobe pin exists. When the data line is high at a falling edge of the serial clock, the register contents are copied into an output latch. The parallel outputs show the inverted latch contents, so each output ends up equal to the data level that was sent for its bit. The outputs hold until the next copy.

A reset pin from the controller clears the register and the latch for as long as it is held high, and all outputs then read 1. The three serial inputs are asynchronous to the system clock. They pass through synchronizers, and the serial clock edges are found in the system clock domain.

Top module: `serial_port_expander`

## Requirements
- R1: At a rising serial clock edge, the register takes in the complement of the data level. Data high stores 0 and data low stores 1. This bit appears at output index 0 as the original data level once it is latched.
- R2: Each shift moves every register stage one place toward the highest index. After N bits are latched, output bit k equals the data level of the bit sent k positions before the last one.
- R3: Any bit shifted beyond the ninth stage is lost. A frame longer than nine bits shows only its last nine bits, and a frame shorter than nine bits keeps the older bits in the upper positions.
- R4: A falling serial clock edge with the data line high copies the whole register into the latch.
- R5: A falling serial clock edge with the data line low, and any rising edge, leaves the latch and the outputs unchanged.
- R6: `par_out` is the bitwise inverse of the latch. It changes only on a latch copy or a clear.
- R7: While `ser_clr` is high, the register and the latch are held at 0, so every output reads 1. Serial activity during the pulse has no effect. After release, the cleared register stages read 1 when the next frame is latched.
- R8: The system reset `rst` clears the register and the latch in the same way, so every output reads 1.
- R9: With two synchronizer stages, the outputs take the new value on the third system clock edge after the strobe falling edge reaches the pins, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| ser_clk | input | 1 | Serial clock from the controller (asynchronous) |
| ser_dat | input | 1 | Serial data, which also acts as the latch strobe (asynchronous) |
| ser_clr | input | 1 | Active-high clear from the controller (asynchronous) |
| par_out | output | 9 | Parallel outputs, the inverted latch contents |

## Verification
Every pin change passes through two synchronizer flops, and the register or latch then updates on the next edge. An output result is therefore due on the third system clock edge after the serial pin moves. The bench drives the pins on falling system clock edges. It samples the outputs two falling edges after the strobe, where the old value must still be present, and again at three, where the new value must be present. It also checks a long settle time later, which shows that the value holds. Just before each strobe, after the last rising edge, the bench checks that the outputs have not moved. During clears, it samples several times across the whole pulse.

// File: rtl/spx_pkg.sv
package spx_pkg;

    // Positions of the serial pins inside the synchronizer vector
    typedef enum int unsigned {
        CH_CLK = 0,
        CH_DAT = 1,
        CH_CLR = 2
    } sync_ch_e;

    localparam int unsigned NUM_CH = 3;

    // Per-cycle serial events in the system clock domain
    typedef struct packed {
        logic clr;   // synchronized clear level
        logic rise;  // serial clock rose this cycle
        logic fall;  // serial clock fell this cycle
        logic dat;   // data sample aligned with the edge
    } ser_evt_t;

    // A falling edge with data high loads the latch
    function automatic logic is_strobe(input ser_evt_t e);
        return e.fall & e.dat;
    endfunction

endpackage

// File: rtl/spx_sync.sv
module spx_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2   // must be at least 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/spx_edge.sv
module spx_edge
    import spx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] sync_in,
    output ser_evt_t          evt
);

    logic sclk_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sync_in[CH_CLK];
        end
    end

    always_comb begin
        evt.rise = sync_in[CH_CLK] & ~sclk_prev_q;
        evt.fall = ~sync_in[CH_CLK] & sclk_prev_q;
        evt.dat  = sync_in[CH_DAT];
        evt.clr  = sync_in[CH_CLR];
    end

endmodule

// File: rtl/spx_core.sv
module spx_core
    import spx_pkg::*;
#(
    parameter int unsigned WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  ser_evt_t         evt,
    output logic [WIDTH-1:0] latch_q
);

    logic [WIDTH-1:0] stage_q;
    logic             wipe;

    assign wipe = rst | evt.clr;

    always_ff @(posedge clk) begin
        if (wipe) begin
            stage_q <= '0;
            latch_q <= '0;
        end else begin
            if (evt.rise) begin
                stage_q <= {stage_q[WIDTH-2:0], ~evt.dat};
            end
            if (is_strobe(evt)) begin
                latch_q <= stage_q;
            end
        end
    end

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.rise && !evt.clr) |=> (stage_q[0] == !$past(evt.dat)));

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.rise && !evt.clr) |=> (stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0])));

    // R4
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.fall && evt.dat && !evt.clr) |=> (latch_q == $past(stage_q)));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(evt.fall && evt.dat) && !evt.clr) |=> $stable(latch_q));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        evt.clr |=> (stage_q == '0 && latch_q == '0));

endmodule

// File: rtl/serial_port_expander.sv
module serial_port_expander
    import spx_pkg::*;
#(
    parameter int unsigned WIDTH       = 9,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_clr,
    output logic [WIDTH-1:0] par_out
);

    logic [NUM_CH-1:0] pins_raw;
    logic [NUM_CH-1:0] pins_sync;
    ser_evt_t          evt;
    logic [WIDTH-1:0]  latch_q;

    assign pins_raw = {ser_clr, ser_dat, ser_clk};

    spx_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_raw),
        .dout (pins_sync)
    );

    spx_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (pins_sync),
        .evt     (evt)
    );

    spx_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .latch_q (latch_q)
    );

    assign par_out = ~latch_q;

    // R6
    out_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_strobe(evt) && !evt.clr) |=> $stable(par_out));

    // R8
    sys_reset_chk: assert property (@(posedge clk)
        rst |=> (par_out == '1));

endmodule

// File: tb/serial_port_expander_tb.sv
module serial_port_expander_tb;

    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_clk = 1'b0;
    logic         ser_dat = 1'b0;
    logic         ser_clr = 1'b0;
    logic [W-1:0] par_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] cur_out;

    // {bit count, bits sent MSB first, expected outputs}
    localparam logic [29:0] VEC [0:7] = '{
        {5'd9,  16'h00A5, 9'h0A5},
        {5'd9,  16'h015A, 9'h15A},
        {5'd4,  16'h0003, 9'h1A3},
        {5'd12, 16'h0F0F, 9'h10F},
        {5'd1,  16'h0000, 9'h01E},
        {5'd13, 16'h1FFF, 9'h1FF},
        {5'd9,  16'h0000, 9'h000},
        {5'd5,  16'h0016, 9'h016}
    };

    always #2 clk = ~clk;

    serial_port_expander u_dut (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .ser_clr (ser_clr),
        .par_out (par_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one serial bit with no strobe at its falling edge
    task automatic send_plain(input logic b);
        ser_dat = b;  tick(4);
        ser_clk = 1'b1; tick(4);
        ser_dat = 1'b0; tick(4);
        ser_clk = 1'b0; tick(4);
    endtask

    // frame without checks, strobe on the last bit
    task automatic send_raw(input int n, input logic [15:0] bits);
        for (int i = n - 1; i >= 0; i--) begin
            if (i > 0) begin
                send_plain(bits[i]);
            end else begin
                ser_dat = bits[0]; tick(4);
                ser_clk = 1'b1;    tick(4);
                ser_dat = 1'b1;    tick(4);
                ser_clk = 1'b0;    tick(4);
                ser_dat = 1'b0;    tick(4);
            end
        end
    endtask

    // checked frame: outputs hold until the strobe, then switch on the third edge
    task automatic frame(input int n, input logic [15:0] bits, input logic [W-1:0] exp);
        for (int i = n - 1; i >= 0; i--) begin
            if (i > 0) begin
                send_plain(bits[i]);
            end else begin
                ser_dat = bits[0]; tick(4);
                ser_clk = 1'b1;    tick(4);
                chk(par_out, cur_out, "R5 rise leaves outputs");
                ser_dat = 1'b1;    tick(4);
                ser_clk = 1'b0;    tick(2);
                chk(par_out, cur_out, "R9 not before third edge");
                tick(1);
                chk(par_out, exp, "R4 R1 R2 R3 strobe load");
                tick(4);
                ser_dat = 1'b0;    tick(8);
                chk(par_out, exp, "R6 outputs hold");
            end
        end
        cur_out = exp;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(5);
        chk(par_out, 9'h1FF, "R8 reset state");
        rst = 1'b0;
        tick(4);
        chk(par_out, 9'h1FF, "R8 after reset release");
        cur_out = 9'h1FF;

        for (int v = 0; v < 8; v++) begin
            frame(int'(VEC[v][29:25]), VEC[v][24:9], VEC[v][8:0]);
        end

        // R5: falling edges with data low do nothing
        send_plain(1'b1);
        send_plain(1'b1);
        send_plain(1'b1);
        tick(4);
        chk(par_out, 9'h016, "R5 fall with data low");
        frame(1, 16'h0000, 9'h16E);

        // R7: clear pin held across serial activity
        ser_clr = 1'b1;
        tick(3);
        chk(par_out, 9'h1FF, "R7 clear takes effect");
        send_raw(5, 16'h0010);
        chk(par_out, 9'h1FF, "R7 mid pulse");
        send_raw(9, 16'h00F0);
        chk(par_out, 9'h1FF, "R7 end of pulse");
        ser_clr = 1'b0;
        tick(6);
        chk(par_out, 9'h1FF, "R7 after release");
        cur_out = 9'h1FF;
        frame(3, 16'h0005, 9'h1FD);

        // R8: system reset mid run
        rst = 1'b1;
        tick(5);
        chk(par_out, 9'h1FF, "R8 reset mid run");
        rst = 1'b0;
        tick(4);
        cur_out = 9'h1FF;
        frame(2, 16'h0002, 9'h1FE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule